// File: doc/BRIEF.md
# Station Address Checksum Verifier

This block reads a network station address from a byte-wide address ROM and checks it against the checksum stored after it. A start pulse launches a run. The block then asks for bytes one at a time by holding a read request high. It keeps the first six bytes as the 48-bit station address. It also folds them, taken as three little-endian 16-bit words, into a rotating end-around-carry sum. The two bytes that follow form the stored checksum, low byte first, and are compared with the folded sum.

The block is meant to run immediately after a signature search has placed the ROM's read position at the first address byte. When the eighth byte has been taken, the block raises a done pulse for one cycle. In that same cycle it presents the address and the match result, and it holds both until the next run completes.

Top module: `sa_csum_check`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `rom_rd`, `done` and `csum_ok` are 0 and `station_addr` is all zeros.
- R2: A `start` pulse seen while idle raises `rom_rd` in the next cycle. `rom_rd` then stays high until eight bytes have been taken. A byte is taken on a clock edge where `rom_rd` and `rom_vld` are both 1. `rom_vld` has no effect while idle.
- R3: The six address bytes keep their read order. The first byte read lands in `station_addr[47:40]` and the sixth in `station_addr[7:0]`.
- R4: Bytes 0-1, 2-3 and 4-5 each form one 16-bit word. The earlier byte of each pair is the low half of the word.
- R5: Before each word is added, the running sum (starting from 0) is doubled. If the doubled value is above 0xFFFF, 0xFFFF is subtracted from it.
- R6: The word is then added. If the result is above 0xFFFF, 0xFFFF is subtracted again.
- R7: After the third word, a sum of exactly 0xFFFF is replaced by 0 before the comparison.
- R8: Bytes 6 and 7 form the stored checksum, byte 6 being the low half. `csum_ok` is 1 exactly when the stored checksum equals the final sum.
- R9: `done` is high for one cycle only: the cycle after the eighth byte is taken. During that cycle `rom_rd` is low.
- R10: `csum_ok` and `station_addr` change only at the edge that raises `done`, and hold their values otherwise. A `start` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a verification run (honoured only while idle) |
| rom_rd | output | 1 | Byte request; high while a run needs bytes |
| rom_vld | input | 1 | A ROM byte is present on `rom_byte` |
| rom_byte | input | 8 | ROM data byte |
| station_addr | output | 48 | Station address, first byte read in the top octet |
| csum_ok | output | 1 | Stored checksum equals the computed one |
| done | output | 1 | One-cycle pulse marking the end of a run |

## Verification
The assertions assume the ROM side is passive. `rom_vld` may be high at any time, and it counts only while `rom_rd` is high. The properties also assume `start` is a level sampled on clock edges with no timing of its own. Because of this, the done-count check can rely on a tally of accepted bytes kept since the last idle start.

The stimulus sends every byte with a random number of idle cycles in front of it. It injects a stray `start` in the middle of a run, and it toggles `rom_vld` with junk data between runs. None of this breaks those assumptions, and it exercises the paths where inputs must be ignored. The directed frames hit the doubling overflow, the addition overflow, the 0xFFFF-to-zero rule and a byte-swapped stored checksum.

// File: rtl/sa_csum_check.sv
module sa_csum_check #(
  parameter int WORDS = 3,
  parameter int BW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  rom_rd,
  input  logic                  rom_vld,
  input  logic [BW-1:0]         rom_byte,
  output logic [2*WORDS*BW-1:0] station_addr,
  output logic                  csum_ok,
  output logic                  done
);
  localparam int ABYTES = 2 * WORDS;
  localparam int TOTAL  = ABYTES + 2;
  localparam int CW     = $clog2(TOTAL + 1);
  localparam int WW     = 2 * BW;
  localparam int AW     = ABYTES * BW;
  localparam logic [WW:0] MAXV = {1'b0, {WW{1'b1}}};

  logic          busy;
  logic [CW-1:0] cnt;
  logic [BW-1:0] lo;
  logic [WW:0]   acc;
  logic [AW-1:0] shreg;

  logic          take, hi_byte, in_addr, last;
  logic [WW-1:0] word, fin;
  logic [WW:0]   dbl, dbl_f, sum, sum_f;

  assign rom_rd  = busy;
  assign take    = busy & rom_vld;
  assign hi_byte = cnt[0];
  assign in_addr = cnt < CW'(ABYTES);
  assign last    = cnt == CW'(TOTAL - 1);
  assign word    = {rom_byte, lo};

  assign dbl   = {acc[WW-1:0], 1'b0};
  assign dbl_f = (dbl > MAXV) ? dbl - MAXV : dbl;
  assign sum   = dbl_f + {1'b0, word};
  assign sum_f = (sum > MAXV) ? sum - MAXV : sum;
  assign fin   = (acc[WW-1:0] == {WW{1'b1}}) ? '0 : acc[WW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      cnt          <= '0;
      lo           <= '0;
      acc          <= '0;
      shreg        <= '0;
      station_addr <= '0;
      csum_ok      <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          acc  <= '0;
        end
      end else if (take) begin
        cnt <= cnt + 1'b1;
        if (!hi_byte) lo <= rom_byte;
        if (in_addr) shreg <= {shreg[AW-BW-1:0], rom_byte};
        if (in_addr && hi_byte) acc <= sum_f;
        if (last) begin
          busy         <= 1'b0;
          done         <= 1'b1;
          csum_ok      <= (fin == word);
          station_addr <= shreg;
        end
      end
    end
  end
endmodule

// File: rtl/sa_csum_check_chk.sv
module sa_csum_check_chk #(
  parameter int WORDS = 3,
  parameter int BW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            rom_rd,
  input logic            rom_vld,
  input logic            csum_ok,
  input logic            done,
  input logic [2*BW:0]   acc
);
  localparam int TOTAL = 2 * WORDS + 2;
  localparam logic [2*BW:0] MAXV = {1'b0, {(2*BW){1'b1}}};

  int unsigned taken;
  always_ff @(posedge clk) begin
    if (!rst_n) taken <= 0;
    else if (!rom_rd && start) taken <= 0;
    else if (rom_rd && rom_vld) taken <= taken + 1;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !rom_rd);
  // R2
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> taken == TOTAL);
  // R2
  rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rom_rd) |-> $past(start));
  // R10
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(rst_n)) |-> $stable(csum_ok));
  // R5
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) acc <= MAXV);
endmodule

bind sa_csum_check sa_csum_check_chk #(.WORDS(WORDS), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .rom_rd(rom_rd), .rom_vld(rom_vld),
  .csum_ok(csum_ok), .done(done), .acc(acc)
);

// File: tb/sa_csum_check_tb_top.sv
module sa_csum_check_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rom_vld = 1'b0;
  logic [7:0]  rom_byte = 8'h00;
  logic        rom_rd, csum_ok, done;
  logic [47:0] station_addr;

  always #2.5 clk = ~clk;

  sa_csum_check dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rom_rd(rom_rd), .rom_vld(rom_vld),
    .rom_byte(rom_byte), .station_addr(station_addr), .csum_ok(csum_ok), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  function automatic int ref_sum(input logic [63:0] f);
    int s = 0;
    for (int w = 0; w < 3; w++) begin
      s = s * 2;
      if (s > 65535) s = s - 65535;
      s = s + int'(f[16*w +: 8]) + int'(f[16*w+8 +: 8]) * 256;
      if (s > 65535) s = s - 65535;
    end
    if (s == 65535) s = 0;
    return s;
  endfunction

  function automatic logic [47:0] ref_addr(input logic [63:0] f);
    logic [47:0] a;
    for (int i = 0; i < 6; i++) a[47-8*i -: 8] = f[8*i +: 8];
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on the same edges as the design
  bit          m_busy = 0, m_done = 0, m_ok = 0;
  logic [47:0] m_addr = '0;
  logic [7:0]  m_q[$];
  always @(posedge clk) begin
    m_done <= 0;
    if (!rst_n) begin
      m_busy <= 0; m_ok <= 0; m_addr <= '0; m_q.delete();
    end else if (!m_busy) begin
      if (start) begin m_busy <= 1; m_q.delete(); end
    end else if (rom_vld) begin
      m_q.push_back(rom_byte);
      if (m_q.size() == 8) begin
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[8*i +: 8] = m_q[i];
        m_busy <= 0; m_done <= 1;
        m_ok   <= (ref_sum(f) == int'(f[48 +: 8]) + int'(f[56 +: 8]) * 256);
        m_addr <= ref_addr(f);
      end
    end
  end

  always @(negedge clk) begin
    chk(rom_rd == m_busy, "R2 rom_rd", 64'(rom_rd), 64'(m_busy));
    chk(done == m_done, "R9 done", 64'(done), 64'(m_done));
    chk(csum_ok == m_ok, "R8 csum_ok", 64'(csum_ok), 64'(m_ok));
    chk(station_addr == m_addr, "R3 station_addr", 64'(station_addr), 64'(m_addr));
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  task automatic run_frame(input logic [63:0] f, input bit exp_ok, input string req, input bit poke);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 8; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      rom_vld = 1; rom_byte = f[8*i +: 8];
      if (poke && i == 3) start = 1;
      @(negedge clk);
      rom_vld = 0; start = 0;
    end
    chk(done == 1'b1, "R9 done after last byte", 64'(done), 64'd1);
    chk(csum_ok == exp_ok, req, 64'(csum_ok), 64'(exp_ok));
    chk(station_addr == ref_addr(f), "R3 address order", 64'(station_addr), 64'(ref_addr(f)));
    @(negedge clk);
    chk(done == 1'b0, "R9 single pulse", 64'(done), 64'd0);
    rom_vld = 1; rom_byte = 8'hA5;
    @(negedge clk);
    rom_vld = 0;
    chk(rom_rd == 1'b0, "R2 vld ignored when idle", 64'(rom_rd), 64'd0);
    chk(csum_ok == exp_ok, "R10 result held", 64'(csum_ok), 64'(exp_ok));
  endtask

  initial begin
    logic [63:0] f;
    repeat (3) @(negedge clk);
    chk(rom_rd == 0 && done == 0 && csum_ok == 0, "R1 reset outputs", {rom_rd, done, csum_ok}, 64'd0);
    chk(station_addr == '0, "R1 reset address", 64'(station_addr), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(station_addr == '0 && !done, "R1 after release", 64'(station_addr), 64'd0);

    f = {16'h0, 48'h5a4b3c2d1e0f};
    f[63:48] = 16'(ref_sum(f));
    run_frame(f, 1, "R8 good checksum", 0);
    f[63:48] = f[63:48] + 16'd1;
    run_frame(f, 0, "R8 bad checksum", 0);
    run_frame({16'h0000, 48'hffff_0000_0000}, 1, "R7 0xFFFF becomes 0", 0);
    run_frame({16'hffff, 48'hffff_0000_0000}, 0, "R7 stored 0xFFFF rejected", 0);
    run_frame({16'h0002, 48'h0000_0001_ffff}, 1, "R5 R6 folded overflow", 0);
    run_frame({16'h0003, 48'h0000_0001_ffff}, 0, "R6 off-by-one rejected", 0);
    run_frame({16'h0004, 48'h0000_0000_0001}, 1, "R4 low byte first", 0);
    run_frame({16'h0400, 48'h0000_0000_0001}, 0, "R8 swapped stored bytes", 0);
    run_frame({16'h0004, 48'h0000_0000_0001}, 1, "R10 start during run ignored", 1);
    for (int k = 0; k < 20; k++) begin
      f = {$urandom, $urandom};
      f[63:48] = 16'(ref_sum(f));
      run_frame(f, 1, "R8 random good", k[0]);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule